// File: doc/BRIEF.md
# Bit-serial reciprocal generator

This unit takes an N-bit unsigned integer V and returns an N-bit fixed-point fraction R, with every bit to the right of the binary point, that approximates 1/V. R starts at zero and is settled one bit per clock, from the most significant fraction bit down. At step i the unit forms a trial sum: the running product R×V plus V×2^-i. If the trial sum does not go above 1.0, the bit is set and the trial sum is kept as the new running product. An N-bit input therefore takes exactly N additions.

The input side is a valid/ready stream. A value is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low for the whole computation, and an upstream source has to hold its value until it sees ready. The result side has no back-pressure. `done` pulses for one cycle when the last bit is settled, and `out_r` then holds the result until the next input is accepted. `busy` is a plain status pin.

Top module: `recip_serial`

## Requirements
- R1: `in_ready` is high exactly when the unit is not computing. An input is taken only on an edge where `in_valid` and `in_ready` are both high, and `busy` is high in the cycle after that edge.
- R2: `done` is high for exactly one cycle, N clock edges after the accepting edge. `busy` falls at the same edge.
- R3: For V ≥ 2 the result is the largest N-bit fraction R with R×V ≤ 1.0. As an integer this is floor(2^N / V), with bit N-1 weighing 2^-1.
- R4: For V = 1 the result is all ones.
- R5: For V = 0 the result is all ones, and `done` still pulses after N steps.
- R6: The running product never exceeds 1.0.
- R7: `in_valid` during a computation is ignored: the result belongs to the first value accepted. `out_r` stays stable from `done` until the next accepting edge.
- R8: After reset, `in_ready` is 1, `busy` is 0, `done` is 0 and `out_r` is 0.
- R9: Bits are settled most significant first. While busy, after k steps `out_r` holds the top k bits of the final result and zeros below them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input value offered |
| in_ready | output | 1 | Unit idle, input can be taken |
| in_v | input | N | Unsigned operand V |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle pulse, result complete |
| out_r | output | N | Reciprocal fraction, all bits after the point |

## Verification
The accepting edge is the first edge at which `in_valid` and `in_ready` are both high. After that edge, `done` and the final `out_r` are due exactly N edges later, and `done` must be low on every earlier edge and on the edge after it. A partial result is due after N/2 edges. The bench counts edges from the accepting one, samples each on the falling clock, and compares the outputs against a function computed from floor(2^N/V). It checks `done` at every sample, not only at the expected one. In one run the bench drives a different operand onto `in_valid` while the unit is busy, then checks that the result still matches the first operand.

// File: rtl/recip_pkg.sv
package recip_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} recip_state_e;
endpackage

// File: rtl/recip_trial.sv
// Combinational trial step: adds V scaled by 2^-(i) to the running product
// and reports whether the result stays at or below 1.0.
module recip_trial #(
  parameter int N    = 16,
  parameter int CW   = $clog2(N + 1)
) (
  input  logic [N:0]    sum_q,
  input  logic [N-1:0]  v_q,
  input  logic [CW-1:0] shamt,
  output logic          fits,
  output logic [N:0]    sum_d
);
  localparam int TW = 2 * N + 1;
  localparam logic [TW-1:0] ONE = TW'(1) << N;

  logic [TW-1:0] addend;
  logic [TW-1:0] trial;

  always_comb begin
    addend = TW'(v_q) << shamt;
    trial  = TW'(sum_q) + addend;
    fits   = (trial <= ONE);
    sum_d  = trial[N:0];
  end
endmodule

// File: rtl/recip_seq.sv
// Step sequencer: counts settled bits and flags the final step.
module recip_seq
  import recip_pkg::*;
#(
  parameter int N  = 16,
  parameter int CW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          last,
  output logic          done,
  output logic [CW-1:0] step
);
  localparam logic [CW-1:0] LAST_STEP = CW'(N - 1);

  recip_state_e state_q;

  assign busy = (state_q == ST_RUN);
  assign last = busy && (step == LAST_STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step    <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state_q == ST_IDLE) begin
        if (start) begin
          state_q <= ST_RUN;
          step    <= '0;
        end
      end else if (last) begin
        state_q <= ST_IDLE;
        step    <= '0;
        done    <= 1'b1;
      end else begin
        step <= step + 1'b1;
      end
    end
  end

  p_start_runs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_follows_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
endmodule

// File: rtl/recip_serial.sv
module recip_serial
  import recip_pkg::*;
#(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [N-1:0] in_v,
  output logic         busy,
  output logic         done,
  output logic [N-1:0] out_r
);
  localparam int CW = $clog2(N + 1);
  localparam logic [N:0]   ONE_SUM = (N+1)'(1) << N;
  localparam logic [N-1:0] ONES    = '1;

  logic [N:0]    sum_q;
  logic [N:0]    sum_d;
  logic [N-1:0]  v_q;
  logic [CW-1:0] step;
  logic [CW-1:0] shamt;
  logic          fits;
  logic          last;
  logic          accept;

  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;
  assign shamt    = CW'(N - 1) - step;

  recip_seq #(.N(N), .CW(CW)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (accept),
    .busy  (busy),
    .last  (last),
    .done  (done),
    .step  (step)
  );

  recip_trial #(.N(N), .CW(CW)) u_trial (
    .sum_q (sum_q),
    .v_q   (v_q),
    .shamt (shamt),
    .fits  (fits),
    .sum_d (sum_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      v_q   <= '0;
      out_r <= '0;
    end else if (accept) begin
      sum_q <= '0;
      v_q   <= in_v;
      out_r <= '0;
    end else if (busy && fits) begin
      sum_q        <= sum_d;
      out_r[shamt] <= 1'b1;
    end
  end

  p_sum_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sum_q <= ONE_SUM);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !accept) |=> $stable(out_r));
  p_msb_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((out_r & (ONES >> step)) == '0));
  p_v_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> $stable(v_q));
endmodule

// File: tb/test_recip_serial.sv
module test_recip_serial;
  localparam int N = 12;
  localparam time CLK_PERIOD = 10;
  localparam int WATCHDOG = 200000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [N-1:0] in_v = '0;
  logic         busy;
  logic         done;
  logic [N-1:0] out_r;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  recip_serial #(.N(N)) i_recip_serial (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_v(in_v), .busy(busy), .done(done), .out_r(out_r)
  );

  function automatic logic [N-1:0] expect_r(input logic [N-1:0] v);
    longint q;
    if (v == 0) return '1;
    q = (longint'(1) << N) / longint'(v);
    if (q > (longint'(1) << N) - 1) q = (longint'(1) << N) - 1;
    return q[N-1:0];
  endfunction

  task automatic check(input bit ok, input string req, input longint act,
                       input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [N-1:0] v, input bit poke, input string req);
    logic [N-1:0] exp;
    logic [N-1:0] top_mask;
    exp = expect_r(v);
    @(negedge clk);
    check(in_ready == 1'b1, "R1 ready idle", in_ready, 1);
    in_valid = 1'b1;
    in_v = v;
    @(negedge clk);
    in_valid = 1'b0;
    check(busy == 1'b1 && in_ready == 1'b0, "R1 busy after accept", busy, 1);
    for (int k = 1; k <= N; k++) begin
      if (poke && k == 2) begin
        in_valid = 1'b1;
        in_v = ~v;
      end
      @(negedge clk);
      if (poke && k == 2) in_valid = 1'b0;
      if (k < N) begin
        if (done) check(0, "R2 early done", done, 0);
      end
      if (k == N / 2) begin
        top_mask = ~({N{1'b1}} >> k);
        check(out_r == (exp & top_mask), "R9 partial msb first", out_r,
              exp & top_mask);
      end
    end
    check(done == 1'b1 && busy == 1'b0, "R2 done after N", done, 1);
    check(out_r == exp, req, out_r, exp);
    @(negedge clk);
    check(done == 1'b0, "R2 single pulse", done, 0);
    check(out_r == exp, "R7 result held", out_r, exp);
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [N-1:0] rv;
    void'($urandom(32'd1234));
    #(CLK_PERIOD * 2);
    // R8 reset state
    check(in_ready == 1 && busy == 0 && done == 0 && out_r == 0, "R8 reset",
          {in_ready, busy, done}, 3'b100);
    @(negedge clk);
    rst_n = 1'b1;
    run(12'd1, 0, "R4 V=1 all ones");
    run(12'd0, 0, "R5 V=0 all ones");
    run(12'd2, 0, "R3 V=2");
    run(12'd3, 0, "R3 V=3");
    run(12'hFFF, 0, "R3 V=max");
    run(12'd7, 1, "R7 input ignored while busy");
    for (int n = 0; n < 40; n++) begin
      rv = N'($urandom);
      run(rv, 0, "R3 random");
    end
    // R6 corner: power-of-two operands give exact products
    run(12'd64, 0, "R6 R3 exact power of two");
    finish_up();
  end
endmodule